// File: doc/BRIEF.md
# Five-State Irregular Sequence Counter

A synchronous counter holding a three-bit state, written with the bits ordered C, B, A from most to least significant. It does not count in binary. While enabled, each clock moves it one step around a fixed loop of five codes: 000, 100, 111, 010, 011, and back to 000. The three codes outside the loop (001, 101, 110) are each given a next state that lands on the loop in a single clock, so the counter recovers from any upset.

The next-state decode is shared. It drives one storage element per bit through that element's excitation rule. The parameter `STYLE` chooses the element type: 0 for D, 1 for toggle (T), 2 for set/reset (S-R) and 3 for J-K. Every style walks the same sequence. The parameter `RST_CODE` gives the state that the synchronous reset loads. Its default is 000. Other values exist so that a bench can start the counter on an unused code.

Top module: `seq5_counter`

## Requirements
- R1: With `rst` low and `en` high, each rising clock edge moves `state` (bits C,B,A) along the loop 000→100→111→010→011→000.
- R2: With `rst` low and `en` high, the unused codes step as follows: 001→100, 101→000, 110→000.
- R3: With `rst` low and `en` low, `state` holds its value across the clock edge.
- R4: With `rst` high at a rising edge, `state` takes `RST_CODE` (default 000) at that edge, whatever the value of `en`.
- R5: With `STYLE`=0, each bit is a D element whose input is the bit's wanted next value, and the state follows R1–R4.
- R6: With `STYLE`=1, each bit is a T element whose toggle input is the XOR of the bit's wanted next value and its present value, and the state follows R1–R4.
- R7: With `STYLE`=2, each bit is an S-R element. Set is raised only for a 0→1 change and reset only for a 1→0 change, never both at once, and the state follows R1–R4.
- R8: With `STYLE`=3, each bit is a J-K element. J is raised for 0→1 and K for 1→0, the free input of a holding bit takes a don't-care value, and the state follows R1–R4.
- R9: All four styles, reset to the same code and given the same `en` and `rst`, show identical `state` on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to `RST_CODE` |
| en | input | 1 | Count enable; state holds when low |
| state | output | 3 | Present state, bit 2 = C, bit 1 = B, bit 0 = A |

## Verification
Every result is due exactly one rising edge after the inputs that cause it: a reset load, a hold and a step all appear on `state` at the first edge that samples them. The bench changes `en` and `rst` only on falling edges. A behavioural reference updates on the rising edge that the design uses, and each `state` is compared with it at the next falling edge, so the check looks at the value produced by that single edge. Sixteen instances, covering four styles and four reset codes (000 and the three unused codes), are compared with the reference and with each other on every cycle.

// File: rtl/seq5_counter.sv
module seq5_counter #(
  parameter int unsigned STYLE    = 0,
  parameter logic [2:0]  RST_CODE = 3'b000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  output logic [2:0] state
);
  localparam int NB = 3;

  logic [NB-1:0] q;
  logic [NB-1:0] nxt;

  always_comb begin
    case (q)
      3'b000:  nxt = 3'b100;
      3'b100:  nxt = 3'b111;
      3'b111:  nxt = 3'b010;
      3'b010:  nxt = 3'b011;
      3'b011:  nxt = 3'b000;
      3'b001:  nxt = 3'b100;
      default: nxt = 3'b000;
    endcase
  end

  generate
    if (STYLE == 1) begin : g_t
      logic [NB-1:0] t;
      assign t = {NB{en}} & (nxt ^ q);
      always_ff @(posedge clk)
        if (rst) q <= RST_CODE;
        else     q <= q ^ t;
    end else if (STYLE == 2) begin : g_sr
      logic [NB-1:0] s, r;
      assign s = {NB{en}} &  nxt & ~q;
      assign r = {NB{en}} & ~nxt &  q;
      always_ff @(posedge clk)
        if (rst) q <= RST_CODE;
        else
          for (int b = 0; b < NB; b++)
            if (s[b])      q[b] <= 1'b1;
            else if (r[b]) q[b] <= 1'b0;
    end else if (STYLE == 3) begin : g_jk
      logic [NB-1:0] j, k;
      assign j = {NB{en}} &  nxt;
      assign k = {NB{en}} & ~nxt;
      always_ff @(posedge clk)
        if (rst) q <= RST_CODE;
        else
          for (int b = 0; b < NB; b++)
            case ({j[b], k[b]})
              2'b10:   q[b] <= 1'b1;
              2'b01:   q[b] <= 1'b0;
              2'b11:   q[b] <= ~q[b];
              default: q[b] <= q[b];
            endcase
    end else begin : g_d
      logic [NB-1:0] d;
      assign d = en ? nxt : q;
      always_ff @(posedge clk)
        if (rst) q <= RST_CODE;
        else     q <= d;
    end
  endgenerate

  assign state = q;
endmodule

// File: rtl/seq5_counter_chk.sv
module seq5_counter_chk #(
  parameter logic [2:0] RST_CODE = 3'b000
) (
  input logic       clk,
  input logic       rst,
  input logic       en,
  input logic [2:0] state
);
  // R1
  loop_a_chk: assert property (@(posedge clk) disable iff (rst)
    (en && state == 3'b000) |=> state == 3'b100);
  // R1
  loop_b_chk: assert property (@(posedge clk) disable iff (rst)
    (en && state == 3'b100) |=> state == 3'b111);
  // R1
  loop_c_chk: assert property (@(posedge clk) disable iff (rst)
    (en && state == 3'b111) |=> state == 3'b010);
  // R1
  loop_d_chk: assert property (@(posedge clk) disable iff (rst)
    (en && state == 3'b010) |=> state == 3'b011);
  // R1
  loop_e_chk: assert property (@(posedge clk) disable iff (rst)
    (en && state == 3'b011) |=> state == 3'b000);
  // R2
  unused_one_chk: assert property (@(posedge clk) disable iff (rst)
    (en && state == 3'b001) |=> state == 3'b100);
  // R2
  unused_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (en && (state == 3'b101 || state == 3'b110)) |=> state == 3'b000);
  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(state));
  // R4
  reset_load_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> state == RST_CODE);
endmodule

bind seq5_counter seq5_counter_chk #(.RST_CODE(RST_CODE)) u_chk (
  .clk(clk), .rst(rst), .en(en), .state(state)
);

// File: tb/sim_seq5_counter.sv
`timescale 1ns/1ps
module sim_seq5_counter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  always #2.5 clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  bit started = 1'b0;
  bit done = 1'b0;

  logic [2:0] q0;
  logic [2:0] qv [4][4];
  int refq [4];
  string mode_tag [4];
  string style_tag [4];
  int codes [4];

  initial begin
    codes = '{0, 1, 5, 6};
    style_tag = '{"R5", "R6", "R7", "R8"};
    mode_tag = '{"R4", "R4", "R4", "R4"};
  end

  seq5_counter #(.STYLE(0), .RST_CODE(3'b000)) u0 (
    .clk(clk), .rst(rst), .en(en), .state(q0));

  for (genvar si = 0; si < 4; si++) begin : g_s
    for (genvar ci = 0; ci < 4; ci++) begin : g_c
      localparam logic [2:0] RC = (ci == 0) ? 3'b000 : (ci == 1) ? 3'b001 :
                                  (ci == 2) ? 3'b101 : 3'b110;
      logic [2:0] qo;
      seq5_counter #(.STYLE(si), .RST_CODE(RC)) u (
        .clk(clk), .rst(rst), .en(en), .state(qo));
      assign qv[si][ci] = qo;
    end
  end

  function automatic int ref_next(int s);
    case (s)
      0: return 4;
      4: return 7;
      7: return 2;
      2: return 3;
      3: return 0;
      1: return 4;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    for (int c = 0; c < 4; c++) begin
      if (rst) begin
        mode_tag[c] = "R4";
        refq[c] = codes[c];
      end else if (!en) begin
        mode_tag[c] = "R3";
      end else begin
        mode_tag[c] = (refq[c] == 1 || refq[c] == 5 || refq[c] == 6) ? "R2" : "R1";
        refq[c] = ref_next(refq[c]);
      end
    end
    started = 1'b1;
  end

  task automatic check_all();
    if (!started) return;
    compared++;
    if (q0 !== refq[0][2:0]) begin
      mismatched++;
      $display("FAIL %s R5 u0: state=%b expected=%b", mode_tag[0], q0, refq[0][2:0]);
    end
    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 4; c++) begin
        compared++;
        if (qv[s][c] !== refq[c][2:0]) begin
          mismatched++;
          $display("FAIL %s %s code=%0d: state=%b expected=%b",
                   mode_tag[c], style_tag[s], codes[c], qv[s][c], refq[c][2:0]);
        end
      end
    for (int c = 0; c < 4; c++)
      for (int s = 1; s < 4; s++) begin
        compared++;
        if (qv[s][c] !== qv[0][c]) begin
          mismatched++;
          $display("FAIL R9 style%0d code=%0d: state=%b expected=%b",
                   s, codes[c], qv[s][c], qv[0][c]);
        end
      end
  endtask

  task automatic step(input logic r, input logic e);
    @(negedge clk);
    check_all();
    rst = r;
    en  = e;
  endtask

  initial begin
    repeat (3) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    repeat (12) step(1'b0, 1'b1);
    for (int i = 0; i < 20; i++) step(1'b0, i[0]);
    step(1'b1, 1'b1);
    step(1'b1, 1'b0);
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    step(1'b0, 1'b0);
    for (int i = 0; i < 300; i++) step(($urandom % 37) == 0, ($urandom % 3) != 0);
    step(1'b0, 1'b0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog R1: run did not end, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule